// File: doc/BRIEF.md
# Synchronous FIFO USB Bridge with Clock-Domain Crossing

This block connects a fast signal-processing clock domain to an external USB bridge chip that exposes an 8-bit synchronous FIFO. The chip supplies the FIFO clock, and all bus activity runs on that clock. Producers in the fast domain ask for a packet with a single-cycle request pulse. The request crosses into the FIFO clock domain as a toggle. The block then serializes either an 11-byte data packet or a 26-byte status packet onto the byte bus. It writes a byte only while the chip reports transmit space.

When the bus is not used for transmission, the block watches the chip's receive-available flag. It then reads 4-byte host commands with a small read sequencer and presents each complete command for one cycle. The two bus directions never overlap. A pending or active transmission stops a new read from starting. A read that is already underway finishes before any transmission begins.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While rst_ni is low, wr_no, rd_no and oe_no are high and fifo_drive_o and cmd_valid_o are low.
- R2: A data packet is 11 bytes, sent in the order data_pkt_i[87:80] first through data_pkt_i[7:0] last. A byte counts as written on a fifo clock edge where both wr_no and txe_ni are low.
- R3: While txe_ni is high, no byte is written and fifo_data_o holds its value. When txe_ni returns low, the packet resumes with no byte lost or repeated.
- R4: A status packet is 26 bytes, sent in this order: header 0xBB, status words 0 to 5 (each most significant byte first), then trailer 0x55. Words 1 to 5 come from status_words_i, with word 1 in bits [159:128].
- R5: Status word 0 is {8'hFF, mode_i[1:0], stream_i[2:0], 3'b000, threshold_i[15:0]}.
- R6: A single-cycle request pulse in the processing domain produces exactly one packet. The payload inputs are captured when that packet starts and must be held stable until then.
- R7: A status request that arrives while a data packet is being sent is held and sent right after it. When both kinds are pending at once, the data packet goes first.
- R8: In a command read, oe_no goes low at least one cycle before rd_no first goes low. rd_no is low only while rxf_ni is low, and one byte is taken on each edge where both are low. The first byte received becomes cmd_o[31:24].
- R9: After the fourth byte, cmd_valid_o is high for exactly one cycle, with the assembled command on cmd_o.
- R10: rd_no is never low while fifo_drive_o is high. A read does not start while a packet is pending or active. A read already in progress completes before a packet starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_proc_i | input | 1 | Processing domain clock |
| clk_fifo_i | input | 1 | FIFO clock from the USB chip |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_req_i | input | 1 | Data packet request pulse (processing domain) |
| data_pkt_i | input | 88 | Data packet payload |
| status_req_i | input | 1 | Status packet request pulse (processing domain) |
| mode_i | input | 2 | Operating mode field of status word 0 |
| stream_i | input | 3 | Stream selection field of status word 0 |
| threshold_i | input | 16 | Threshold field of status word 0 |
| status_words_i | input | 160 | Status words 1 to 5 |
| txe_ni | input | 1 | Low when the chip can accept a byte |
| wr_no | output | 1 | Active-low write strobe |
| fifo_drive_o | output | 1 | High while the block drives the byte bus |
| fifo_data_o | output | 8 | Outgoing byte |
| rxf_ni | input | 1 | Low when the chip holds a received byte |
| oe_no | output | 1 | Active-low output enable for the chip's receive data |
| rd_no | output | 1 | Active-low read strobe |
| fifo_data_i | input | 8 | Incoming byte |
| cmd_o | output | 32 | Assembled host command |
| cmd_valid_o | output | 1 | One-cycle command-valid pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a status request landing while a data packet is on the bus, or both requests arriving in the same processing cycle. The bench triggers the status request after the third data byte is captured, and separately fires both pulses together. It then checks that the 37 captured bytes are the full data packet followed by the full status packet. The second pair is receive data becoming available while a packet is pending, or a packet request arriving mid-command. For these cases the bench raises the receive flag partway through a packet, and it stalls a half-read command before requesting a packet. It checks that rd_no never falls while the bus is driven, and that both the command and the packet arrive intact and in order.

// File: rtl/ufb_pkg.sv
`timescale 1ns/1ps
package ufb_pkg;
  localparam logic [7:0] STAT_HEAD = 8'hBB;
  localparam logic [7:0] STAT_TAIL = 8'h55;
  localparam logic [7:0] W0_MARK   = 8'hFF;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_STAT} tx_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_OE, RD_XFER} rd_state_e;

  function automatic logic [31:0] pack_word0(logic [1:0] mode, logic [2:0] stream,
                                             logic [15:0] thr);
    return {W0_MARK, mode, stream, 3'b000, thr};
  endfunction
endpackage

// File: rtl/ufb_toggle_sync.sv
`timescale 1ns/1ps
module ufb_toggle_sync #(
  parameter int unsigned STAGES = 3
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o
);
  logic              tog_q;
  logic [STAGES:0]   sh_q;

  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni)      tog_q <= 1'b0;
    else if (pulse_i) tog_q <= ~tog_q;

  // STAGES flops for metastability, one more for edge detect
  always_ff @(posedge dst_clk_i or negedge rst_ni)
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], tog_q};

  assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/ufb_tx_serializer.sv
`timescale 1ns/1ps
module ufb_tx_serializer
  import ufb_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 11,
  parameter int unsigned STAT_BYTES = 26,
  localparam int unsigned DATA_W = DATA_BYTES * 8,
  localparam int unsigned STAT_W = STAT_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_hit_i,
  input  logic              stat_hit_i,
  input  logic [DATA_W-1:0] data_pkt_i,
  input  logic [STAT_W-1:0] stat_pkt_i,
  input  logic              hold_i,
  input  logic              txe_ni,
  output logic              claim_o,
  output logic              drive_o,
  output logic              wr_no,
  output logic [7:0]        byte_o
);
  localparam int unsigned IDX_W  = $clog2(STAT_BYTES);
  localparam int unsigned DIDX_W = $clog2(DATA_BYTES);

  tx_state_e                  state_q;
  logic [IDX_W-1:0]           idx_q, last_idx;
  logic                       data_pend_q, stat_pend_q;
  logic [DATA_BYTES-1:0][7:0] data_q, data_ord;
  logic [STAT_BYTES-1:0][7:0] stat_q, stat_ord;
  logic                       start_data, start_stat, active, fire;

  // byte 0 of each buffer is the first byte on the bus
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_dord
    assign data_ord[k] = data_pkt_i[DATA_W-1-8*k -: 8];
  end
  for (genvar k = 0; k < STAT_BYTES; k++) begin : g_sord
    assign stat_ord[k] = stat_pkt_i[STAT_W-1-8*k -: 8];
  end

  assign active     = (state_q != TX_IDLE);
  assign start_data = !active && data_pend_q && !hold_i;
  assign start_stat = !active && !data_pend_q && stat_pend_q && !hold_i;
  assign fire       = active && !txe_ni;
  assign last_idx   = (state_q == TX_DATA) ? IDX_W'(DATA_BYTES - 1) : IDX_W'(STAT_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      data_pend_q <= 1'b0;
      stat_pend_q <= 1'b0;
    end else begin
      data_pend_q <= data_hit_i | (data_pend_q & ~start_data);
      stat_pend_q <= stat_hit_i | (stat_pend_q & ~start_stat);
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
      stat_q  <= '0;
    end else if (start_data) begin
      state_q <= TX_DATA;
      idx_q   <= '0;
      data_q  <= data_ord;
    end else if (start_stat) begin
      state_q <= TX_STAT;
      idx_q   <= '0;
      stat_q  <= stat_ord;
    end else if (fire) begin
      if (idx_q == last_idx) state_q <= TX_IDLE;
      else                   idx_q   <= idx_q + 1'b1;
    end

  always_comb begin
    byte_o = 8'h00;
    case (state_q)
      TX_DATA: byte_o = data_q[idx_q[DIDX_W-1:0]];
      TX_STAT: byte_o = stat_q[idx_q];
      default: byte_o = 8'h00;
    endcase
  end

  assign wr_no   = ~fire;
  assign drive_o = active;
  assign claim_o = active | data_pend_q | stat_pend_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && txe_ni) |=> $stable(byte_o)) else $error("byte changed in stall"); // R3
  AST_DATA_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_DATA) |-> (idx_q < IDX_W'(DATA_BYTES))) else $error("data index"); // R2
  AST_STAT_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_DATA && !(fire && idx_q == last_idx)) |=> (state_q != TX_STAT))
    else $error("status cut into data"); // R7
endmodule

// File: rtl/ufb_cmd_reader.sv
`timescale 1ns/1ps
module ufb_cmd_reader
  import ufb_pkg::*;
#(
  parameter int unsigned CMD_BYTES = 4,
  localparam int unsigned CMD_W = CMD_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             rxf_ni,
  input  logic [7:0]       data_i,
  output logic             oe_no,
  output logic             rd_no,
  output logic             busy_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_valid_o
);
  localparam int unsigned CNT_W = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] sh_q;
  logic             take;

  assign take = (state_q == RD_XFER) && !rxf_ni;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= RD_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      case (state_q)
        RD_IDLE: if (enable_i && !rxf_ni) begin
          state_q <= RD_OE;
          cnt_q   <= '0;
        end
        RD_OE:   state_q <= RD_XFER;
        RD_XFER: if (take) begin
          sh_q  <= {sh_q[CMD_W-9:0], data_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CMD_BYTES - 1)) begin
            state_q     <= RD_IDLE;
            cmd_o       <= {sh_q[CMD_W-9:0], data_i};
            cmd_valid_o <= 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end

  assign oe_no  = (state_q == RD_IDLE);
  assign rd_no  = ~take;
  assign busy_o = (state_q != RD_IDLE);

  AST_OE_LEADS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> $past(!oe_no)) else $error("rd before oe"); // R8
  AST_CMD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o) else $error("cmd valid too long"); // R9
endmodule

// File: rtl/usb_fifo_bridge.sv
`timescale 1ns/1ps
module usb_fifo_bridge
  import ufb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned DATA_BYTES  = 11,
  parameter int unsigned STAT_WORDS  = 6,
  parameter int unsigned CMD_BYTES   = 4,
  localparam int unsigned STAT_BYTES = STAT_WORDS * 4 + 2,
  localparam int unsigned DATA_W     = DATA_BYTES * 8,
  localparam int unsigned XW_W       = (STAT_WORDS - 1) * 32,
  localparam int unsigned CMD_W      = CMD_BYTES * 8
) (
  input  logic              clk_proc_i,
  input  logic              clk_fifo_i,
  input  logic              rst_ni,
  input  logic              data_req_i,
  input  logic [DATA_W-1:0] data_pkt_i,
  input  logic              status_req_i,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        stream_i,
  input  logic [15:0]       threshold_i,
  input  logic [XW_W-1:0]   status_words_i,
  input  logic              txe_ni,
  output logic              wr_no,
  output logic              fifo_drive_o,
  output logic [7:0]        fifo_data_o,
  input  logic              rxf_ni,
  output logic              oe_no,
  output logic              rd_no,
  input  logic [7:0]        fifo_data_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_valid_o
);
  logic                    data_hit, stat_hit, tx_claim, rd_busy;
  logic [STAT_BYTES*8-1:0] stat_pkt;

  assign stat_pkt = {STAT_HEAD, pack_word0(mode_i, stream_i, threshold_i),
                     status_words_i, STAT_TAIL};

  ufb_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
    .src_clk_i(clk_proc_i), .dst_clk_i(clk_fifo_i), .rst_ni(rst_ni),
    .pulse_i(data_req_i), .pulse_o(data_hit));

  ufb_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_stat (
    .src_clk_i(clk_proc_i), .dst_clk_i(clk_fifo_i), .rst_ni(rst_ni),
    .pulse_i(status_req_i), .pulse_o(stat_hit));

  ufb_tx_serializer #(.DATA_BYTES(DATA_BYTES), .STAT_BYTES(STAT_BYTES)) u_tx (
    .clk_i(clk_fifo_i), .rst_ni(rst_ni),
    .data_hit_i(data_hit), .stat_hit_i(stat_hit),
    .data_pkt_i(data_pkt_i), .stat_pkt_i(stat_pkt),
    .hold_i(rd_busy), .txe_ni(txe_ni),
    .claim_o(tx_claim), .drive_o(fifo_drive_o), .wr_no(wr_no), .byte_o(fifo_data_o));

  ufb_cmd_reader #(.CMD_BYTES(CMD_BYTES)) u_rd (
    .clk_i(clk_fifo_i), .rst_ni(rst_ni),
    .enable_i(!tx_claim), .rxf_ni(rxf_ni), .data_i(fifo_data_i),
    .oe_no(oe_no), .rd_no(rd_no), .busy_o(rd_busy),
    .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o));

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk_fifo_i) disable iff (!rst_ni)
    !(fifo_drive_o && !oe_no)) else $error("bus driven both ways"); // R10
  AST_NO_RD_IN_TX: assert property (@(posedge clk_fifo_i) disable iff (!rst_ni)
    fifo_drive_o |-> rd_no) else $error("read during transmit"); // R10
endmodule

// File: tb/usb_fifo_bridge_test.sv
`timescale 1ns/1ps
module usb_fifo_bridge_test;
  logic clk = 1'b0, clk_p = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;
  always #1.5 clk_p = ~clk_p;

  logic         data_req = 0, status_req = 0;
  logic [87:0]  data_pkt = '0;
  logic [1:0]   mode = '0;
  logic [2:0]   stream = '0;
  logic [15:0]  thr = '0;
  logic [159:0] words = '0;
  logic         txe_n = 1'b1, rxf_n = 1'b1;
  logic [7:0]   din = '0;
  logic         wr_n, drive, oe_n, rd_n, cmd_valid;
  logic [7:0]   dout;
  logic [31:0]  cmd;

  usb_fifo_bridge uut (
    .clk_proc_i(clk_p), .clk_fifo_i(clk), .rst_ni(rst_n),
    .data_req_i(data_req), .data_pkt_i(data_pkt), .status_req_i(status_req),
    .mode_i(mode), .stream_i(stream), .threshold_i(thr), .status_words_i(words),
    .txe_ni(txe_n), .wr_no(wr_n), .fifo_drive_o(drive), .fifo_data_o(dout),
    .rxf_ni(rxf_n), .oe_no(oe_n), .rd_no(rd_n), .fifo_data_i(din),
    .cmd_o(cmd), .cmd_valid_o(cmd_valid));

  localparam int NVEC = 4;
  localparam logic [87:0] PKT_TAB [NVEC] = '{
    88'h0102030405060708090A0B, 88'hFFEEDDCCBBAA9988776655,
    88'h00FF00FF00FF00FF00FF00, 88'hDEADBEEFCAFE0123456789};
  localparam logic [15:0] STALL_TAB [NVEC] = '{16'h0000, 16'h00F0, 16'hAAAA, 16'h0FFF};

  logic [7:0]  cap [64];
  logic [7:0]  rx_mem [8];
  logic [7:0]  exp_b [64];
  int          cap_n = 0, rx_len = 0, rx_pos = 0, cyc = 0;
  int          rd_in_tx = 0, oe_viol = 0, cmdv_n = 0;
  logic        rd_will = 1'b0, prev_oe = 1'b1, done = 1'b0;
  logic [15:0] stall_pat = '0;
  logic [31:0] cmd_seen = '0;
  int          checks = 0, fails = 0;

  // chip model and bus monitor
  always @(negedge clk) begin
    if (rd_will) rx_pos++;
    txe_n <= stall_pat[cyc % 16];
    cyc++;
    rxf_n <= !(rx_pos < rx_len);
    din   <= (rx_pos < rx_len) ? rx_mem[rx_pos % 8] : 8'h00;
    #1;
    if (!wr_n && !txe_n) begin
      if (cap_n < 64) cap[cap_n] = dout;
      cap_n++;
    end
    if (!rd_n && drive) rd_in_tx++;
    if (!rd_n && prev_oe) oe_viol++;
    prev_oe = oe_n;
    if (cmd_valid) begin cmdv_n++; cmd_seen = cmd; end
    rd_will = !rd_n && !rxf_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wait_caps(input int n);
    int t = 0;
    while (cap_n < n && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk(0, "WD", "byte wait timeout", 64'(cap_n), 64'(n));
  endtask

  task automatic wait_cmd(input int n);
    int t = 0;
    while (cmdv_n < n && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk(0, "WD", "command wait timeout", 64'(cmdv_n), 64'(n));
  endtask

  task automatic pulse(input bit d, input bit s);
    @(negedge clk_p); data_req = d; status_req = s;
    @(negedge clk_p); data_req = 0; status_req = 0;
  endtask

  task automatic load_data_exp(input int base, input logic [87:0] p);
    for (int k = 0; k < 11; k++) exp_b[base + k] = 8'(p >> (8 * (10 - k)));
  endtask

  task automatic load_stat_exp(input int base);
    logic [31:0] w;
    exp_b[base] = 8'hBB;
    for (int j = 0; j < 6; j++) begin
      w = (j == 0) ? (32'hFF000000 | (32'(mode) << 22) | (32'(stream) << 19) | 32'(thr))
                   : 32'(words >> (32 * (5 - j)));
      for (int b = 0; b < 4; b++) exp_b[base + 1 + 4*j + b] = 8'(w >> (8 * (3 - b)));
    end
    exp_b[base + 25] = 8'h55;
  endtask

  task automatic cmp(input int base, input int n, input string req, input string what);
    int bad = -1;
    for (int k = base; k < base + n; k++)
      if (bad < 0 && cap[k] !== exp_b[k]) bad = k;
    if (bad < 0) chk(1, req, what, 0, 0);
    else chk(0, req, {what, " byte mismatch"}, 64'(cap[bad]), 64'(exp_b[bad]));
  endtask

  task automatic set_rx(input logic [31:0] v, input int avail);
    for (int k = 0; k < 4; k++) rx_mem[k] = 8'(v >> (8 * (3 - k)));
    rx_pos = 0;
    rx_len = avail;
  endtask

  initial begin
    #800000;
    chk(0, "WD", "global watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(wr_n === 1 && rd_n === 1 && oe_n === 1 && drive === 0 && cmd_valid === 0,
        "R1", "reset outputs", {59'b0, wr_n, rd_n, oe_n, drive, cmd_valid}, 64'h1C);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R6: table of payloads under different stall patterns
    for (int i = 0; i < NVEC; i++) begin
      stall_pat = STALL_TAB[i];
      data_pkt  = PKT_TAB[i];
      cap_n = 0;
      load_data_exp(0, PKT_TAB[i]);
      pulse(1, 0);
      wait_caps(11);
      repeat (40) @(negedge clk);
      chk(cap_n == 11, "R6", "one packet per request", 64'(cap_n), 11);
      cmp(0, 11, (STALL_TAB[i] == 0) ? "R2" : "R3", "data packet");
    end

    // R3: full stall blocks all writes, then releases intact
    stall_pat = 16'hFFFF;
    data_pkt = 88'h112233445566778899AABB;
    load_data_exp(0, data_pkt);
    cap_n = 0;
    pulse(1, 0);
    repeat (40) @(negedge clk);
    chk(cap_n == 0 && wr_n == 1, "R3", "no write while full", 64'(cap_n), 0);
    stall_pat = 16'h0000;
    wait_caps(11);
    cmp(0, 11, "R3", "packet after release");

    // R4 R5: status packet
    mode = 2'b10; stream = 3'b101; thr = 16'h1234;
    words = 160'h11111111_22222222_33333333_44444444_A5A55A5A;
    load_stat_exp(0);
    cap_n = 0;
    pulse(0, 1);
    wait_caps(26);
    repeat (20) @(negedge clk);
    chk(cap_n == 26, "R4", "status length", 64'(cap_n), 26);
    cmp(0, 26, "R4", "status packet");
    chk({cap[1], cap[2], cap[3], cap[4]} == 32'hFFA81234, "R5", "word0 layout",
        64'({cap[1], cap[2], cap[3], cap[4]}), 64'h FFA81234);

    // R7: status request during a data packet
    stall_pat = 16'h3333;
    data_pkt = PKT_TAB[3];
    load_data_exp(0, data_pkt);
    load_stat_exp(11);
    cap_n = 0;
    pulse(1, 0);
    wait_caps(3);
    pulse(0, 1);
    wait_caps(37);
    repeat (20) @(negedge clk);
    chk(cap_n == 37, "R7", "data then status length", 64'(cap_n), 37);
    cmp(0, 37, "R7", "status held behind data");

    // R7: both requests in the same cycle, data first
    stall_pat = 16'h0000;
    data_pkt = PKT_TAB[1];
    load_data_exp(0, data_pkt);
    cap_n = 0;
    pulse(1, 1);
    wait_caps(37);
    cmp(0, 37, "R7", "simultaneous requests order");

    // R8 R9: command read
    cmdv_n = 0; oe_viol = 0;
    set_rx(32'hA1B2C3D4, 4);
    wait_cmd(1);
    repeat (10) @(negedge clk);
    chk(cmd_seen == 32'hA1B2C3D4, "R8", "command bytes", 64'(cmd_seen), 64'hA1B2C3D4);
    chk(cmdv_n == 1, "R9", "valid pulse count", 64'(cmdv_n), 1);
    chk(oe_viol == 0 && rx_pos == 4, "R8", "oe lead and byte count", 64'(oe_viol), 0);

    // R8: command bytes trickle in
    cmdv_n = 0;
    set_rx(32'h11223344, 2);
    repeat (20) @(negedge clk);
    chk(cmdv_n == 0 && rx_pos == 2, "R8", "partial command waits", 64'(rx_pos), 2);
    rx_len = 4;
    wait_cmd(1);
    repeat (5) @(negedge clk);
    chk(cmd_seen == 32'h11223344 && cmdv_n == 1, "R9", "command after gap",
        64'(cmd_seen), 64'h11223344);

    // R10: receive data appears during a packet
    stall_pat = 16'h00FF;
    rd_in_tx = 0; cmdv_n = 0;
    data_pkt = PKT_TAB[0];
    load_data_exp(0, data_pkt);
    cap_n = 0;
    pulse(1, 0);
    wait_caps(2);
    set_rx(32'h5A6B7C8D, 4);
    wait_caps(11);
    wait_cmd(1);
    repeat (5) @(negedge clk);
    chk(rd_in_tx == 0, "R10", "no read while driving", 64'(rd_in_tx), 0);
    cmp(0, 11, "R10", "packet intact beside read");
    chk(cmd_seen == 32'h5A6B7C8D, "R10", "read after packet", 64'(cmd_seen), 64'h5A6B7C8D);

    // R10: read in progress blocks a packet until it completes
    stall_pat = 16'h0000;
    cmdv_n = 0;
    set_rx(32'hC0FFEE01, 2);
    repeat (10) @(negedge clk);
    data_pkt = PKT_TAB[2];
    load_data_exp(0, data_pkt);
    cap_n = 0;
    pulse(1, 0);
    repeat (20) @(negedge clk);
    chk(cap_n == 0, "R10", "packet waits for read", 64'(cap_n), 0);
    rx_len = 4;
    wait_cmd(1);
    wait_caps(11);
    chk(cmd_seen == 32'hC0FFEE01, "R10", "blocked read completes", 64'(cmd_seen), 64'hC0FFEE01);
    cmp(0, 11, "R10", "packet after read");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule